// File: doc/BRIEF.md
# Programmable Clock Divider with Shifted Companion Output

This block divides a fast input clock by an integer ratio between 1 and 32 and drives two outputs: the divided clock itself and a companion clock. The companion follows the divided clock, delayed by zero to three input cycles. It can be inverted or held off. A five-bit ratio code selects the division, where code zero stands for the largest ratio. A flag reports when the divider has started after reset.

Ratio changes are sampled only in the last input cycle of a period, so every period that has already begun runs at its full old length. The delay, the inversion and the enable of the companion may be changed at any time without disturbing the divided clock. A ratio of one cannot be produced by a counter, so the block switches both outputs to pass the input clock through. In that mode the delay and the inversion have no effect.

Top module: `clkdiv_phased`

## Requirements
- R1: The ratio N is 32 for code 0 and equals the code for codes 1 to 31; each period of the divided output lasts N input cycles.
- R2: For N of 2 or more, each period begins with the divided output rising; it stays high for floor(N/2) input cycles and low for the remaining cycles.
- R3: While reset is asserted, the divided output, the companion output and the running flag are all low. The first period after reset uses N = 16, whatever the code input holds.
- R4: The ratio code is taken only at the edge that ends a period. A code change in mid-period leaves the length of the current period unchanged, and the next period uses the new ratio.
- R5: When enabled, with inversion off and N of 2 or more, the companion output sampled after input edge k equals the divided output sampled after edge k-S, where S (0 to 3) is the delay input.
- R6: With inversion on and N of 2 or more, the companion is the complement of the value R5 gives.
- R7: While the companion enable is low, the companion output is low in every cycle.
- R8: When N = 1, the divided output follows the input clock. The companion follows the input clock when enabled and is low otherwise; the delay and inversion inputs have no effect.
- R9: The running flag is low in reset, high from the first input edge after reset is released, and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_code_i | input | CODE_W (5) | Ratio code; 0 selects 32 |
| shift_i | input | SHIFT_W (2) | Companion delay in input cycles |
| flip_i | input | 1 | Invert the companion output |
| phase_en_i | input | 1 | Enable the companion output |
| div_clk_o | output | 1 | Divided clock |
| phase_clk_o | output | 1 | Delayed, optionally inverted companion clock |
| running_o | output | 1 | Divider has started since reset |

## Verification
Some properties are checked on every cycle. The count never leaves the current ratio, and it restarts after the last count. The ratio register holds between boundaries. A disabled companion is low. With no delay, the companion matches the divided clock, or its complement when inverted. The running flag stays set once high, and reset holds all three outputs low. Some behaviour is visible only in the bench's scenarios: the high and low times measured for every ratio code, the exact lag for each delay, a mid-period change of ratio, and pass-through at a ratio of one, which shows on both clock phases.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int unsigned CD_CODE_W    = 5;
    localparam int unsigned CD_SHIFT_W   = 2;
    localparam int unsigned CD_RESET_DIV = 16;
endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode #(
    parameter int unsigned CODE_W = 5
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W:0]   ratio_o
);
    localparam int unsigned RATIO_W = CODE_W + 1;
    localparam logic [RATIO_W-1:0] MAX_RATIO = RATIO_W'(1) << CODE_W;

    always_comb begin
        if (code_i == '0) begin
            ratio_o = MAX_RATIO;
        end else begin
            ratio_o = {1'b0, code_i};
        end
    end
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int unsigned CODE_W    = 5,
    parameter int unsigned RESET_DIV = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W:0]   ratio_i,
    output logic [CODE_W-1:0] cnt_o,
    output logic [CODE_W:0]   ratio_o,
    output logic              main_o,
    output logic              main_next_o,
    output logic              run_o
);
    localparam int unsigned RATIO_W = CODE_W + 1;
    localparam logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(RESET_DIV);

    typedef struct packed {
        logic [CODE_W-1:0]  cnt;
        logic [RATIO_W-1:0] ratio;
        logic               main;
        logic               run;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       last_cycle;

    always_comb begin
        st_d       = st_q;
        last_cycle = ({1'b0, st_q.cnt} == (st_q.ratio - RATIO_W'(1)));
        if (!st_q.run) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (last_cycle) begin
            st_d.cnt   = '0;
            st_d.ratio = ratio_i;
        end else begin
            st_d.cnt = st_q.cnt + CODE_W'(1);
        end
        st_d.main = st_d.run && ({1'b0, st_d.cnt} < (st_d.ratio >> 1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt   <= '0;
            st_q.ratio <= RATIO_RST;
            st_q.main  <= 1'b0;
            st_q.run   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o       = st_q.cnt;
    assign ratio_o     = st_q.ratio;
    assign main_o      = st_q.main;
    assign main_next_o = st_d.main;
    assign run_o       = st_q.run;
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase #(
    parameter int unsigned SHIFT_W = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               main_next_i,
    input  logic [SHIFT_W-1:0] shift_i,
    input  logic               flip_i,
    input  logic               en_i,
    input  logic               bypass_i,
    output logic               phase_o
);
    localparam int unsigned MAX_SHIFT = (1 << SHIFT_W) - 1;

    typedef struct packed {
        logic [MAX_SHIFT-1:0] line;
        logic                 phase;
    } ph_state_t;

    ph_state_t          st_d, st_q;
    logic [SHIFT_W-1:0] eff_shift;
    logic               tap;

    always_comb begin
        st_d         = st_q;
        st_d.line[0] = main_next_i;
        for (int i = 1; i < MAX_SHIFT; i++) begin
            st_d.line[i] = st_q.line[i-1];
        end
        eff_shift = bypass_i ? '0 : shift_i;
        tap       = main_next_i;
        for (int i = 1; i <= MAX_SHIFT; i++) begin
            if (eff_shift == SHIFT_W'(i)) begin
                tap = st_q.line[i-1];
            end
        end
        st_d.phase = en_i & (tap ^ (flip_i & ~bypass_i));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.line  <= '0;
            st_q.phase <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
endmodule

// File: rtl/clkdiv_phased.sv
module clkdiv_phased
    import clkdiv_pkg::*;
#(
    parameter int unsigned CODE_W    = CD_CODE_W,
    parameter int unsigned SHIFT_W   = CD_SHIFT_W,
    parameter int unsigned RESET_DIV = CD_RESET_DIV
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [CODE_W-1:0]  div_code_i,
    input  logic [SHIFT_W-1:0] shift_i,
    input  logic               flip_i,
    input  logic               phase_en_i,
    output logic               div_clk_o,
    output logic               phase_clk_o,
    output logic               running_o
);
    localparam int unsigned RATIO_W = CODE_W + 1;

    logic [RATIO_W-1:0] ratio_sel;
    logic [RATIO_W-1:0] ratio_q;
    logic [CODE_W-1:0]  cnt_q;
    logic               main_q;
    logic               main_d;
    logic               run_q;
    logic               phase_q;
    logic               bypass;

    clkdiv_decode #(.CODE_W(CODE_W)) u_dec (
        .code_i  (div_code_i),
        .ratio_o (ratio_sel)
    );

    clkdiv_counter #(.CODE_W(CODE_W), .RESET_DIV(RESET_DIV)) u_cnt (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ratio_i     (ratio_sel),
        .cnt_o       (cnt_q),
        .ratio_o     (ratio_q),
        .main_o      (main_q),
        .main_next_o (main_d),
        .run_o       (run_q)
    );

    assign bypass = (ratio_q == RATIO_W'(1));

    clkdiv_phase #(.SHIFT_W(SHIFT_W)) u_ph (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .main_next_i (main_d),
        .shift_i     (shift_i),
        .flip_i      (flip_i),
        .en_i        (phase_en_i),
        .bypass_i    (bypass),
        .phase_o     (phase_q)
    );

    assign div_clk_o   = bypass ? clk_i : main_q;
    assign phase_clk_o = bypass ? (phase_en_i & clk_i) : phase_q;
    assign running_o   = run_q;
endmodule

// File: rtl/clkdiv_phased_chk.sv
module clkdiv_phased_chk #(
    parameter int unsigned CODE_W  = 5,
    parameter int unsigned SHIFT_W = 2
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               phase_en_i,
    input logic               flip_i,
    input logic [SHIFT_W-1:0] shift_i,
    input logic               running_o,
    input logic               div_clk_o,
    input logic               phase_clk_o,
    input logic [CODE_W-1:0]  cnt_q,
    input logic [CODE_W:0]    ratio_q,
    input logic               main_q,
    input logic               phase_q,
    input logic               bypass
);
    logic at_end;
    assign at_end = running_o && ({1'b0, cnt_q} == (ratio_q - 1'b1));

    p_cnt_in_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        {1'b0, cnt_q} < ratio_q);

    p_wrap_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        at_end |=> (cnt_q == '0));

    p_reset_quiet_r3: assert property (@(posedge clk_i)
        !rst_ni |-> (!running_o && !div_clk_o && !phase_clk_o));

    p_ratio_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !at_end |=> $stable(ratio_q));

    p_shift0_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_en_i && !flip_i && shift_i == '0) |=> (phase_q == main_q));

    p_flip_inverts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_en_i && flip_i && shift_i == '0 && !bypass) |=> (phase_q != main_q));

    p_phase_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !phase_en_i |=> !phase_q);

    p_run_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running_o |=> running_o);
endmodule

bind clkdiv_phased clkdiv_phased_chk #(.CODE_W(CODE_W), .SHIFT_W(SHIFT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_en_i  (phase_en_i),
    .flip_i      (flip_i),
    .shift_i     (shift_i),
    .running_o   (running_o),
    .div_clk_o   (div_clk_o),
    .phase_clk_o (phase_clk_o),
    .cnt_q       (cnt_q),
    .ratio_q     (ratio_q),
    .main_q      (main_q),
    .phase_q     (phase_q),
    .bypass      (bypass)
);

// File: tb/sim_clkdiv_phased.sv
`timescale 1ns/1ps
module sim_clkdiv_phased;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic [4:0] code = 5'd5;
    logic [1:0] shift = 2'd0;
    logic       flip = 1'b0;
    logic       en = 1'b1;
    logic       div_clk, ph_clk, running;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic last_div = 1'b0;
    logic hist [0:3];

    always #10 clk = ~clk;

    clkdiv_phased u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .div_code_i  (code),
        .shift_i     (shift),
        .flip_i      (flip),
        .phase_en_i  (en),
        .div_clk_o   (div_clk),
        .phase_clk_o (ph_clk),
        .running_o   (running)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
        for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
        hist[0]  = div_clk;
        last_div = div_clk;
    endtask

    // Waits for the next rising divided edge, then counts high and low samples.
    task automatic measure(output int h, output int l);
        logic p;
        p = last_div;
        forever begin
            step();
            if (!p && div_clk) break;
            p = div_clk;
        end
        h = 0;
        while (div_clk) begin h++; step(); end
        l = 0;
        while (!div_clk) begin l++; step(); end
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

    initial begin
        int h, l, h2;
        for (int i = 0; i < 4; i++) hist[i] = 1'b0;
        #1 rst_n = 1'b0;
        repeat (3) step();
        chk("R3 div low in reset", div_clk, 0);
        chk("R3 phase low in reset", ph_clk, 0);
        chk("R9 running low in reset", running, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: first period uses ratio 16 although code is 5
        measure(h, l);
        chk("R9 running after start", running, 1);
        chk("R3 first high time", h, 8);
        chk("R3 first low time", l, 8);

        // R1/R2: every ratio from 2 to 32
        for (int n = 2; n <= 32; n++) begin
            code = 5'(n % 32);
            measure(h, l);
            measure(h, l);
            chk($sformatf("R2 high time N=%0d", n), h, n / 2);
            chk($sformatf("R1 period N=%0d", n), h + l, n);
        end

        // R4: change ratio in mid-period
        code = 5'd10;
        measure(h, l);
        measure(h, l);
        step();
        step();
        code = 5'd4;
        h2 = 3;
        step();
        while (div_clk) begin h2++; step(); end
        l = 0;
        while (!div_clk) begin l++; step(); end
        chk("R4 old high kept", h2, 5);
        chk("R4 old low kept", l, 5);
        measure(h, l);
        chk("R4 new period", h + l, 4);

        // R5/R6/R7: companion for several ratios and every setting
        foreach (code[k]) ;
        for (int ni = 0; ni < 4; ni++) begin
            int n;
            n = (ni == 0) ? 2 : (ni == 1) ? 3 : (ni == 2) ? 5 : 8;
            code = 5'(n);
            measure(h, l);
            measure(h, l);
            for (int e = 0; e < 2; e++) begin
                for (int f = 0; f < 2; f++) begin
                    for (int s = 0; s < 4; s++) begin
                        int bad;
                        logic exp;
                        en = e[0];
                        flip = f[0];
                        shift = 2'(s);
                        repeat (5) step();
                        bad = 0;
                        for (int c = 0; c < 2 * n + 8; c++) begin
                            step();
                            exp = en ? (hist[s] ^ flip) : 1'b0;
                            if (ph_clk !== exp) bad++;
                        end
                        chk($sformatf("%s N=%0d en=%0d flip=%0d shift=%0d mismatches",
                            (e == 0) ? "R7" : (f == 1) ? "R6" : "R5", n, e, f, s), bad, 0);
                    end
                end
            end
        end

        // R8: ratio 1 passes the input clock
        code = 5'd1;
        en = 1'b1;
        flip = 1'b1;
        shift = 2'd3;
        repeat (40) step();
        for (int r = 0; r < 3; r++) begin
            step();
            chk("R8 div follows clk high", div_clk, 1);
            chk("R8 phase follows clk high, flip/shift ignored", ph_clk, 1);
            @(negedge clk);
            #5;
            chk("R8 div follows clk low", div_clk, 0);
            chk("R8 phase follows clk low", ph_clk, 0);
        end
        en = 1'b0;
        step();
        chk("R8 phase off when disabled", ph_clk, 0);
        @(negedge clk);
        #5;
        chk("R8 phase off when disabled, low phase", ph_clk, 0);

        // R4/R1: leave ratio 1 again
        en = 1'b1;
        flip = 1'b0;
        shift = 2'd0;
        code = 5'd16;
        measure(h, l);
        chk("R4 leaving ratio 1 high", h, 8);
        chk("R1 leaving ratio 1 period", h + l, 16);
        chk("R9 running kept", running, 1);

        report();
    end
endmodule